// File: doc/BRIEF.md
# Quasi-Resonant Switching Timer

This block generates the gate-drive pulse for a single-switch flyback or buck-boost power stage that regulates from the primary side. It runs on a fixed reference clock, and every time limit is a parameter counted in reference-clock cycles. Comparators outside the block supply two flags. The peak-current flag rises when the switch current reaches its limit. The zero-current flag is high while the auxiliary-winding voltage is below its threshold, which marks the end of demagnetization. An outer control loop supplies a requested switching period and, in fixed mode, a requested on-time.

A pulse starts at a demagnetization valley, once the requested period has elapsed. The requested period is held inside the minimum and maximum period limits. If no valley is seen, a pulse is forced when the maximum period expires. A pulse ends on a peak-current trip that falls after the leading-edge blanking window. The on-time is kept between its minimum and maximum limits. For each cycle the block reports the demagnetization time, counted from gate turn-off to the first qualified zero-current sample, so the outer loop can use it.

Top module: `qr_gate_timer`

## Requirements
- R1: While `rst_n` is low and afterwards, `gate` and `demag_vld` are low. With `enable` low no pulse is produced. When `enable` is first seen high, `gate` rises at the next clock edge.
- R2: A high `pk_trip` is ignored while fewer than LEB_CYC cycles have passed since `gate` rose. A trip sampled in the cycle where exactly LEB_CYC cycles have passed is accepted.
- R3: An accepted peak trip never ends the pulse before MIN_ON_CYC cycles of `gate` high. A one-cycle trip accepted earlier than that is held, and the pulse ends at exactly MIN_ON_CYC cycles.
- R4: With no accepted trip, `gate` falls after exactly MAX_ON_CYC cycles high.
- R5: In peak mode (`fixed_on` = 0), a level trip that starts in cycle t of the pulse (1 = first cycle high, t above both limits) gives an on-time of t cycles.
- R6: With `fixed_on` = 1, `pk_trip` is ignored and the on-time is `req_on` clamped to the range [MIN_ON_CYC, MAX_ON_CYC].
- R7: `zcd_low` is ignored during the first ZCD_BLANK_CYC cycles after `gate` falls. A measured demagnetization time is never below ZCD_BLANK_CYC.
- R8: When the period is already satisfied, the gate rises at the edge right after the first qualified `zcd_low` sample. The resulting period is the on-time plus the demagnetization time plus one.
- R9: A valley that comes before the target period is held. The gate then rises exactly the target period after the previous rise. The target is `req_period` clamped to the period limits.
- R10: The period between rises is never below MIN_PER_CYC and never above MAX_PER_CYC, for any `req_period`.
- R11: With no valley, the next pulse is forced exactly MAX_PER_CYC cycles after the previous rise. That cycle's report has `demag_tmo` = 1, and `demag_time` equals the off-cycles counted up to the restart.
- R12: With `enable` low, `gate` is low one clock later. On re-enable the gate waits until MIN_PER_CYC cycles after the last rise. After a long disable it rises at the next edge.
- R13: Each switching cycle produces exactly one `demag_vld` pulse, one clock wide. `demag_time` holds the number of cycles from `gate` falling to the qualified `zcd_low` sample, and `demag_tmo` = 0 when a valley was found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low forces the gate off |
| pk_trip | input | 1 | Peak-current comparator flag |
| zcd_low | input | 1 | Auxiliary winding below zero-current threshold |
| fixed_on | input | 1 | 1 = fixed on-time mode, 0 = peak-current mode |
| req_on | input | ON_W | Requested on-time in cycles (fixed mode) |
| req_period | input | PER_W | Requested switching period in cycles |
| gate | output | 1 | Gate-drive pulse |
| demag_vld | output | 1 | One-cycle strobe for a new demagnetization report |
| demag_time | output | PER_W | Measured demagnetization time in cycles |
| demag_tmo | output | 1 | Report came from a forced restart, not a valley |

## Verification
The bench answers comparator flags relative to its own count of gate-high and gate-low cycles, then measures each on-time and period. Several boundaries are placed exactly. A one-cycle trip lands one cycle before the blanking window ends and then exactly at its end. A design off by one there would end that pulse at the minimum on-time instead of running to the maximum. A design without the trip latch would miss the short trip and run to the maximum as well. Early valleys must be held to the clamped period, late valleys must be followed at once, and a missing valley must force a restart at the maximum period. A timer that ignored the period would switch too fast, and one without the timeout would stall with the gate low. The disable test re-enables well inside the minimum period and checks that the restart still lands exactly on it. A design that restarted at once would break the frequency ceiling.

// File: rtl/qrt_pkg.sv
package qrt_pkg;
  typedef enum logic [1:0] {
    QRT_IDLE = 2'd0,
    QRT_ON   = 2'd1,
    QRT_OFF  = 2'd2
  } qrt_state_e;
endpackage

// File: rtl/qrt_clamp.sv
// Limits a requested cycle count to a [LO, HI] window.
module qrt_clamp #(
  parameter int W  = 8,
  parameter int LO = 0,
  parameter int HI = 255
) (
  input  logic [W-1:0] raw,
  output logic [W-1:0] lim
);
  localparam logic [W-1:0] LO_V = W'(LO);
  localparam logic [W-1:0] HI_V = W'(HI);

  always_comb begin
    if (raw < LO_V)      lim = LO_V;
    else if (raw > HI_V) lim = HI_V;
    else                 lim = raw;
  end
endmodule

// File: rtl/qrt_on_ctl.sv
// On-phase termination: blanking of the peak flag, trip hold, on-time window.
module qrt_on_ctl #(
  parameter int PW          = 10,
  parameter int OW          = 7,
  parameter int LEB         = 8,
  parameter int MIN_ON      = 20,
  parameter int MAX_ON      = 100,
  parameter bit FIXED_ON_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          on_phase,
  input  logic [PW-1:0] per_cnt,
  input  logic          pk_trip,
  input  logic          fixed_mode,
  input  logic [OW-1:0] on_tgt,
  output logic          on_done
);
  localparam logic [PW-1:0] LEB_V = PW'(LEB);
  localparam logic [PW-1:0] MIN_V = PW'(MIN_ON);
  localparam logic [PW-1:0] MAX_V = PW'(MAX_ON);

  logic          pk_hit_q, pk_hit_d;
  logic          pk_now;
  logic          want_off;
  logic [PW-1:0] on_len;
  logic          floor_ok, ceil_hit;

  // cycles the gate will have been high if it falls at the next edge
  assign on_len = per_cnt + PW'(1);
  assign pk_now = on_phase & pk_trip & (per_cnt >= LEB_V);
  assign pk_hit_d = on_phase & (pk_hit_q | pk_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pk_hit_q <= 1'b0;
    else        pk_hit_q <= pk_hit_d;
  end

  generate
    if (FIXED_ON_EN) begin : g_fixed
      always_comb begin
        if (fixed_mode) want_off = (on_len >= PW'(on_tgt));
        else            want_off = pk_hit_q | pk_now;
      end
    end else begin : g_peak_only
      assign want_off = pk_hit_q | pk_now;
    end
  endgenerate

  assign floor_ok = (on_len >= MIN_V);
  assign ceil_hit = (on_len >= MAX_V);
  assign on_done  = on_phase & (ceil_hit | (floor_ok & want_off));

  // R2: a held trip can only exist once the blanking window has passed
  p_leb_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pk_hit_q |-> (per_cnt > LEB_V));
endmodule

// File: rtl/qrt_off_ctl.sv
// Off-phase: zero-current blanking, valley capture, demagnetization report.
module qrt_off_ctl #(
  parameter int PW        = 10,
  parameter int ZCD_BLANK = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          off_phase,
  input  logic          restart,
  input  logic          zcd_low,
  output logic          valley,
  output logic          demag_vld,
  output logic [PW-1:0] demag_time,
  output logic          demag_tmo
);
  localparam logic [PW-1:0] ZB_V    = PW'(ZCD_BLANK);
  localparam logic [PW-1:0] CNT_TOP = '1;

  logic [PW-1:0] off_cnt_q, off_cnt_d;
  logic          found_q, found_d;
  logic          zcd_ok, timeout, rpt_en;
  logic          vld_q, vld_d;
  logic [PW-1:0] time_q, time_d;
  logic          tmo_q, tmo_d;

  assign zcd_ok  = off_phase & ~found_q & zcd_low & (off_cnt_q >= ZB_V);
  assign valley  = found_q | zcd_ok;
  assign timeout = restart & ~valley;
  assign rpt_en  = zcd_ok | timeout;

  always_comb begin
    if (!off_phase)               off_cnt_d = '0;
    else if (off_cnt_q == CNT_TOP) off_cnt_d = off_cnt_q;
    else                          off_cnt_d = off_cnt_q + PW'(1);
    found_d = off_phase & (found_q | zcd_ok);
    vld_d   = rpt_en;
    time_d  = rpt_en ? off_cnt_q : time_q;
    tmo_d   = rpt_en ? timeout : tmo_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_cnt_q <= '0;
      found_q   <= 1'b0;
      vld_q     <= 1'b0;
      time_q    <= '0;
      tmo_q     <= 1'b0;
    end else begin
      off_cnt_q <= off_cnt_d;
      found_q   <= found_d;
      vld_q     <= vld_d;
      if (rpt_en) begin
        time_q <= time_d;
        tmo_q  <= tmo_d;
      end
    end
  end

  assign demag_vld  = vld_q;
  assign demag_time = time_q;
  assign demag_tmo  = tmo_q;

  // R7: a valley report never lies inside the blanking window
  p_zcd_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (demag_vld && !demag_tmo) |-> (demag_time >= ZB_V));
  // R13: the report strobe is a single-cycle pulse
  p_vld_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
    demag_vld |=> !demag_vld);
endmodule

// File: rtl/qr_gate_timer.sv
module qr_gate_timer
  import qrt_pkg::*;
#(
  parameter int LEB_CYC       = 55,
  parameter int MIN_ON_CYC    = 55,
  parameter int MAX_ON_CYC    = 1280,
  parameter int ZCD_BLANK_CYC = 200,
  parameter int MIN_PER_CYC   = 500,
  parameter int MAX_PER_CYC   = 16667,
  parameter bit FIXED_ON_EN   = 1'b1,
  parameter int PER_W         = $clog2(MAX_PER_CYC + 1),
  parameter int ON_W          = $clog2(MAX_ON_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             pk_trip,
  input  logic             zcd_low,
  input  logic             fixed_on,
  input  logic [ON_W-1:0]  req_on,
  input  logic [PER_W-1:0] req_period,
  output logic             gate,
  output logic             demag_vld,
  output logic [PER_W-1:0] demag_time,
  output logic             demag_tmo
);
  localparam logic [PER_W-1:0] MIN_PER_V  = PER_W'(MIN_PER_CYC);
  localparam logic [PER_W-1:0] MAX_PER_V  = PER_W'(MAX_PER_CYC);
  localparam logic [PER_W-1:0] PER_LAST_V = PER_W'(MAX_PER_CYC - 1);
  localparam logic [PER_W-1:0] MIN_ON_V   = PER_W'(MIN_ON_CYC);
  localparam logic [PER_W-1:0] MAX_ON_V   = PER_W'(MAX_ON_CYC);

  qrt_state_e       st_q, st_d;
  logic [PER_W-1:0] per_q, per_d, per_tick, per_len;
  logic             gate_q, gate_d;
  logic [PER_W-1:0] per_tgt;
  logic [ON_W-1:0]  on_tgt;
  logic             on_done, valley, restart;
  logic             per_due, per_force, min_ok;

  qrt_clamp #(.W(PER_W), .LO(MIN_PER_CYC), .HI(MAX_PER_CYC)) i_per_clamp (
    .raw (req_period),
    .lim (per_tgt)
  );

  qrt_clamp #(.W(ON_W), .LO(MIN_ON_CYC), .HI(MAX_ON_CYC)) i_on_clamp (
    .raw (req_on),
    .lim (on_tgt)
  );

  qrt_on_ctl #(
    .PW(PER_W), .OW(ON_W), .LEB(LEB_CYC), .MIN_ON(MIN_ON_CYC),
    .MAX_ON(MAX_ON_CYC), .FIXED_ON_EN(FIXED_ON_EN)
  ) i_on_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .on_phase   (st_q == QRT_ON),
    .per_cnt    (per_q),
    .pk_trip    (pk_trip),
    .fixed_mode (fixed_on),
    .on_tgt     (on_tgt),
    .on_done    (on_done)
  );

  qrt_off_ctl #(.PW(PER_W), .ZCD_BLANK(ZCD_BLANK_CYC)) i_off_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .off_phase  (st_q == QRT_OFF),
    .restart    (restart),
    .zcd_low    (zcd_low),
    .valley     (valley),
    .demag_vld  (demag_vld),
    .demag_time (demag_time),
    .demag_tmo  (demag_tmo)
  );

  // period counter: cycles since the last rise, saturating at the last slot
  assign per_len   = per_q + PER_W'(1);
  assign per_tick  = (per_q == PER_LAST_V) ? per_q : per_len;
  assign per_due   = (per_len >= per_tgt);
  assign per_force = (per_len >= MAX_PER_V);
  assign min_ok    = (per_len >= MIN_PER_V);

  always_comb begin
    st_d  = st_q;
    per_d = per_tick;
    case (st_q)
      QRT_IDLE: begin
        if (enable && min_ok) begin
          st_d  = QRT_ON;
          per_d = '0;
        end
      end
      QRT_ON: begin
        if (on_done) st_d = QRT_OFF;
      end
      QRT_OFF: begin
        if ((valley && per_due) || per_force) begin
          st_d  = QRT_ON;
          per_d = '0;
        end
      end
      default: st_d = QRT_IDLE;
    endcase
    if (!enable) begin
      st_d  = QRT_IDLE;
      per_d = per_tick;
    end
  end

  assign restart = (st_q == QRT_OFF) && (st_d == QRT_ON);
  assign gate_d  = (st_d == QRT_ON);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= QRT_IDLE;
      per_q  <= PER_LAST_V;
      gate_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      per_q  <= per_d;
      gate_q <= gate_d;
    end
  end

  assign gate = gate_q;

  // R12: disable removes the gate by the next edge
  p_disable_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !gate_q);
  // R3: a pulse ended by the controller is never shorter than the floor
  p_min_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate_q) && $past(enable)) |-> (($past(per_q) + PER_W'(1)) >= MIN_ON_V));
  // R4: the on-time ceiling always ends the pulse
  p_max_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q && (per_len >= MAX_ON_V)) |=> !gate_q);
  // R10: no rise before the minimum period has elapsed
  p_min_per_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_q && (per_len < MIN_PER_V)) |=> !gate_q);
  // R11: the maximum period forces a restart
  p_max_per_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == QRT_OFF) && enable && (per_q == PER_LAST_V)) |=> gate_q);
endmodule

// File: tb/test_qr_gate_timer.sv
module test_qr_gate_timer;
  localparam int LEB     = 8;
  localparam int MIN_ON  = 20;
  localparam int MAX_ON  = 100;
  localparam int ZB      = 15;
  localparam int MIN_PER = 150;
  localparam int MAX_PER = 600;
  localparam int PW      = $clog2(MAX_PER + 1);
  localparam int OW      = $clog2(MAX_ON + 1);
  localparam int NEVER   = 1000000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          enable;
  logic          pk_trip;
  logic          zcd_low;
  logic          fixed_on;
  logic [OW-1:0] req_on;
  logic [PW-1:0] req_period;
  logic          gate;
  logic          demag_vld;
  logic [PW-1:0] demag_time;
  logic          demag_tmo;

  always #5 clk = ~clk;

  qr_gate_timer #(
    .LEB_CYC(LEB), .MIN_ON_CYC(MIN_ON), .MAX_ON_CYC(MAX_ON),
    .ZCD_BLANK_CYC(ZB), .MIN_PER_CYC(MIN_PER), .MAX_PER_CYC(MAX_PER)
  ) i_qr_gate_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pk_trip(pk_trip),
    .zcd_low(zcd_low), .fixed_on(fixed_on), .req_on(req_on),
    .req_period(req_period), .gate(gate), .demag_vld(demag_vld),
    .demag_time(demag_time), .demag_tmo(demag_tmo)
  );

  int checks = 0;
  int fails  = 0;
  // comparator model settings
  int trip_at = NEVER;
  bit trip_pulse = 1'b0;
  int zcd_at = 30;
  // monitor state
  bit gp;
  int hi_n, lo_n, since, last_on, last_per, n_rise, hi_total;
  int cap_dt, cap_tmo, vld_cnt, last_vld;

  // power-stage model and measurement, all at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      gp = 1'b0; hi_n = 0; lo_n = 0; since = 0; last_on = 0; last_per = 0;
      n_rise = 0; hi_total = 0; cap_dt = -1; cap_tmo = -1; vld_cnt = 0; last_vld = 0;
      pk_trip = 1'b0; zcd_low = 1'b0;
    end else begin
      if (demag_vld) begin
        cap_dt = int'(demag_time);
        cap_tmo = int'(demag_tmo);
        vld_cnt++;
      end
      since++;
      if (gate) begin
        hi_total++;
        if (!gp) begin
          hi_n = 1;
          last_per = since - 1;
          since = 1;
          n_rise++;
          last_vld = vld_cnt;
          vld_cnt = 0;
        end else hi_n++;
      end else begin
        if (gp) begin
          last_on = hi_n;
          lo_n = 1;
        end else lo_n++;
      end
      gp = gate;
      pk_trip = gate && (trip_pulse ? (hi_n == trip_at) : (hi_n >= trip_at));
      zcd_low = !gate && (lo_n >= zcd_at);
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_rises(input int k);
    int tgt;
    tgt = n_rise + k;
    while (n_rise < tgt) @(posedge clk);
  endtask

  task automatic cfg(input bit fx, input int on_req, input int t_at, input bit t_pulse,
                     input int z_at, input int per_req);
    @(negedge clk);
    fixed_on   = fx;
    req_on     = OW'(on_req);
    trip_at    = t_at;
    trip_pulse = t_pulse;
    zcd_at     = z_at;
    req_period = PW'(per_req);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; enable = 1'b0; fixed_on = 1'b0; req_on = '0; req_period = PW'(300);
    repeat (5) @(negedge clk);
    check("R1 gate low in reset", int'(gate), 0);
    check("R1 no report in reset", int'(demag_vld), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check("R1 no pulse while disabled", hi_total, 0);
    enable = 1'b1;
    @(negedge clk);
    check("R1 first pulse on next edge", int'(gate), 1);
  endtask

  task automatic t_peak;
    cfg(1'b0, 0, 40, 1'b0, 30, 300);
    wait_rises(2);
    check("R5 level trip on-time", last_on, 40);
    check("R9 held to requested period", last_per, 300);
    check("R13 demag time", cap_dt, 29);
    check("R13 valley flag", cap_tmo, 0);
    check("R13 one report per cycle", last_vld, 1);
  endtask

  task automatic t_leb;
    cfg(1'b0, 0, LEB, 1'b1, 30, 300);
    wait_rises(2);
    check("R2 trip inside blanking ignored", last_on, MAX_ON);
    cfg(1'b0, 0, LEB + 1, 1'b1, 30, 300);
    wait_rises(2);
    check("R2 trip at blanking end accepted", last_on, MIN_ON);
  endtask

  task automatic t_on_limits;
    cfg(1'b0, 0, 12, 1'b1, 30, 300);
    wait_rises(2);
    check("R3 early short trip held to floor", last_on, MIN_ON);
    cfg(1'b0, 0, NEVER, 1'b0, 30, 300);
    wait_rises(2);
    check("R4 no trip hits ceiling", last_on, MAX_ON);
  endtask

  task automatic t_fixed;
    cfg(1'b1, 50, 40, 1'b0, 30, 300);
    wait_rises(2);
    check("R6 fixed on-time ignores trip", last_on, 50);
    cfg(1'b1, 3, 40, 1'b0, 30, 300);
    wait_rises(2);
    check("R6 fixed on-time low clamp", last_on, MIN_ON);
    cfg(1'b1, 120, 40, 1'b0, 30, 300);
    wait_rises(2);
    check("R6 fixed on-time high clamp", last_on, MAX_ON);
  endtask

  task automatic t_zcd;
    cfg(1'b0, 0, 40, 1'b0, 3, 150);
    wait_rises(2);
    check("R7 demag not below blanking", cap_dt, ZB);
    check("R9 early valley held to period", last_per, 150);
    cfg(1'b0, 0, 40, 1'b0, 200, 150);
    wait_rises(2);
    check("R8 late valley demag time", cap_dt, 199);
    check("R8 late valley turn-on", last_per, 240);
    check("R13 one report per cycle late", last_vld, 1);
  endtask

  task automatic t_period_limits;
    cfg(1'b0, 0, 40, 1'b0, 30, 50);
    wait_rises(2);
    check("R10 period floor", last_per, MIN_PER);
    cfg(1'b0, 0, 40, 1'b0, 30, 1000);
    wait_rises(2);
    check("R10 period ceiling", last_per, MAX_PER);
    check("R10 valley found at ceiling", cap_tmo, 0);
  endtask

  task automatic t_timeout;
    cfg(1'b0, 0, 40, 1'b0, NEVER, 150);
    wait_rises(2);
    check("R11 forced restart period", last_per, MAX_PER);
    check("R11 timeout flag", cap_tmo, 1);
    check("R11 timeout count", cap_dt, MAX_PER - 1 - 40);
  endtask

  task automatic t_disable;
    int h0;
    cfg(1'b0, 0, 40, 1'b0, 30, 300);
    wait_rises(1);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R12 gate off within one clock", int'(gate), 0);
    h0 = hi_total;
    repeat (30) @(negedge clk);
    check("R12 gate stays off", hi_total - h0, 0);
    enable = 1'b1;
    wait_rises(1);
    check("R12 re-enable keeps min period", last_per, MIN_PER);
    @(negedge clk);
    enable = 1'b0;
    repeat (700) @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    check("R12 long disable restarts at once", int'(gate), 1);
  endtask

  initial begin
    #(10 * 190000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_peak();
    t_leb();
    t_on_limits();
    t_fixed();
    t_zcd();
    t_period_limits();
    t_timeout();
    t_peak();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule